// File: doc/BRIEF.md
# Per-Axis Single and Double Tap Detector

This block watches two streams of signed acceleration samples, one per axis, and recognises taps on each of them. A tap is a short excursion of the sample magnitude above a per-axis threshold. It must come back below the threshold within a programmed pulse-width limit. After a first tap the axis ignores its input for a programmed dead time. If a second valid tap then starts inside a programmed window, it is reported as a double tap. If the window closes with no second tap, the axis returns to idle.

All timing runs on a `tick` strobe with a period of 0.5 ms. The pulse-width limit counts in ticks. The dead time and the window count in 1 ms units, so each is doubled internally. Samples arrive on `smp_vld` independently of the tick.

Four event flags are collected in a source word together with an interrupt-active bit: single X, double X, single Y and double Y. Each flag has its own enable. The interrupt output is raised whenever a flag is set. In latched mode the flags hold until the source word is read. In unlatched mode they also clear on the next sample.

Top module: `tap_detect`

## Requirements
- R1: The magnitude of an axis sample counts as above the threshold only when it is strictly greater than 4 times that axis's 4-bit threshold code. Positive and negative samples are treated alike. A tap starts on a sample that is above the threshold when the previous sample on that axis was not.
- R2: A tap is valid only if a below-threshold sample arrives after at most `time_lim` ticks have passed since the tap started. A longer excursion produces no event, including when it is the second tap of a pair. After such an excursion the axis waits for the level to fall and then returns to idle.
- R3: After the first valid tap ends, starts are ignored for 2·`latency` ticks. A valid tap that starts within the following 2·`window` ticks sets the double flag of that axis.
- R4: When the window closes without a second start, the axis returns to idle. A later tap is then treated as a new first tap and sets the single flag.
- R5: The bits of `evt_en` and of `src_q[3:0]` are laid out the same way: bit 0 is single X, bit 1 is double X, bit 2 is single Y and bit 3 is double Y. A flag can only be set while its enable bit is 1.
- R6: With `latch_en`=1 the flags hold until `src_rd` is pulsed. With `latch_en`=0 they also clear on the next `smp_vld`. A new event arriving in the same cycle as a clear wins.
- R7: `src_q[4]` and `irq` are both 1 exactly when any flag in `src_q[3:0]` is 1. After reset all outputs are 0.
- R8: The two axes are detected independently. Taps on one axis never affect the flags or the timing of the other axis.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | 0.5 ms time-base strobe |
| smp_vld | input | 1 | A new sample pair is present |
| x_smp | input | DW | X sample, two's complement |
| y_smp | input | DW | Y sample, two's complement |
| thr_x | input | THR_W | X threshold code |
| thr_y | input | THR_W | Y threshold code |
| time_lim | input | TW | Pulse-width limit in ticks |
| latency | input | TW | Dead time in 1 ms units |
| window | input | TW | Second-tap window in 1 ms units |
| evt_en | input | 4 | Per-flag enables |
| latch_en | input | 1 | Hold flags until read |
| src_rd | input | 1 | Source read strobe, clears flags |
| src_q | output | 5 | {active, double Y, single Y, double X, single X} |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is where the second tap starts exactly at the edge of the dead time or of the window. A double tap is only reported inside that interval, and a start just past the window must be taken as a fresh single tap. The bench sweeps the gap between the two taps tick by tick across both edges, for a non-zero dead time and for a zero one. It clears the source word between the taps, so the second tap's own flag shows which of the three outcomes occurred.

// File: rtl/tap_pkg.sv
package tap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE1,
        ST_HOLD,
        ST_LAT,
        ST_WIN,
        ST_PULSE2
    } tap_st_e;

    localparam int N_AXES  = 2;
    localparam int N_FLAGS = 2 * N_AXES;
endpackage

// File: rtl/tap_axis.sv
module tap_axis
    import tap_pkg::*;
#(
    parameter int DW        = 8,
    parameter int THR_W     = 4,
    parameter int THR_SHIFT = 2,
    parameter int TW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          smp_vld,
    input  logic [DW-1:0] smp,
    input  logic [THR_W-1:0] thr,
    input  logic [TW-1:0] time_lim,
    input  logic [TW-1:0] latency,
    input  logic [TW-1:0] window,
    output logic          single_o,
    output logic          double_o
);
    localparam int CW = TW + 1;
    localparam int MW = DW + 1;

    typedef struct packed {
        tap_st_e       st;
        logic [CW-1:0] cnt;
        logic          hi;
    } axis_s;

    axis_s q, d;

    logic [MW-1:0] ext, mag, thr_mag;
    logic [CW-1:0] lim_t, lat_t, win_t, cnt_inc;
    logic          above, rise, fall;

    always_comb begin
        ext     = {smp[DW-1], smp};
        mag     = smp[DW-1] ? (~ext + 1'b1) : ext;
        thr_mag = {{(MW-THR_W){1'b0}}, thr} << THR_SHIFT;
        above   = mag > thr_mag;
        rise    = smp_vld & above & ~q.hi;
        fall    = smp_vld & ~above;
        lim_t   = {1'b0, time_lim};
        lat_t   = {latency, 1'b0};
        win_t   = {window, 1'b0};
        cnt_inc = q.cnt + 1'b1;

        d        = q;
        single_o = 1'b0;
        double_o = 1'b0;
        if (smp_vld) d.hi = above;

        case (q.st)
            ST_IDLE: begin
                if (rise) begin
                    d.st  = ST_PULSE1;
                    d.cnt = '0;
                end
            end
            ST_PULSE1, ST_PULSE2: begin
                if (fall) begin
                    single_o = (q.st == ST_PULSE1);
                    double_o = (q.st == ST_PULSE2);
                    d.st     = (q.st == ST_PULSE1) ? ST_LAT : ST_IDLE;
                    d.cnt    = '0;
                end else if (tick) begin
                    if (cnt_inc > lim_t) d.st = ST_HOLD;
                    else                 d.cnt = cnt_inc;
                end
            end
            ST_HOLD: begin
                if (fall) d.st = ST_IDLE;
            end
            ST_LAT: begin
                if (q.cnt >= lat_t) begin
                    d.st  = ST_WIN;
                    d.cnt = '0;
                end else if (tick) begin
                    d.cnt = cnt_inc;
                end
            end
            ST_WIN: begin
                if (rise) begin
                    d.st  = ST_PULSE2;
                    d.cnt = '0;
                end else if (q.cnt >= win_t) begin
                    d.st = ST_IDLE;
                end else if (tick) begin
                    d.cnt = cnt_inc;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, cnt: '0, hi: 1'b0};
        else        q <= d;
    end
endmodule

// File: rtl/tap_src.sv
module tap_src #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic          latch_en,
    input  logic          src_rd,
    input  logic [NF-1:0] ev,
    input  logic [NF-1:0] en,
    output logic [NF:0]   src_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [NF-1:0] flags;
    } src_s;

    src_s q, d;
    logic keep;

    always_comb begin
        keep    = latch_en ? ~src_rd : ~(src_rd | smp_vld);
        d.flags = (q.flags & {NF{keep}}) | (ev & en);
        irq_o   = |q.flags;
        src_o   = {irq_o, q.flags};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/tap_detect.sv
module tap_detect
    import tap_pkg::*;
#(
    parameter int DW        = 8,
    parameter int THR_W     = 4,
    parameter int THR_SHIFT = 2,
    parameter int TW        = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               smp_vld,
    input  logic [DW-1:0]      x_smp,
    input  logic [DW-1:0]      y_smp,
    input  logic [THR_W-1:0]   thr_x,
    input  logic [THR_W-1:0]   thr_y,
    input  logic [TW-1:0]      time_lim,
    input  logic [TW-1:0]      latency,
    input  logic [TW-1:0]      window,
    input  logic [N_FLAGS-1:0] evt_en,
    input  logic               latch_en,
    input  logic               src_rd,
    output logic [N_FLAGS:0]   src_q,
    output logic               irq
);
    logic [DW-1:0]      smp_a [N_AXES];
    logic [THR_W-1:0]   thr_a [N_AXES];
    logic [N_FLAGS-1:0] ev_all;

    assign smp_a[0] = x_smp;
    assign smp_a[1] = y_smp;
    assign thr_a[0] = thr_x;
    assign thr_a[1] = thr_y;

    for (genvar a = 0; a < N_AXES; a++) begin : g_axis
        tap_axis #(
            .DW(DW), .THR_W(THR_W), .THR_SHIFT(THR_SHIFT), .TW(TW)
        ) u_axis (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .smp_vld  (smp_vld),
            .smp      (smp_a[a]),
            .thr      (thr_a[a]),
            .time_lim (time_lim),
            .latency  (latency),
            .window   (window),
            .single_o (ev_all[2*a]),
            .double_o (ev_all[2*a+1])
        );
    end

    tap_src #(.NF(N_FLAGS)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .latch_en (latch_en),
        .src_rd   (src_rd),
        .ev       (ev_all),
        .en       (evt_en),
        .src_o    (src_q),
        .irq_o    (irq)
    );
endmodule

// File: rtl/tap_detect_chk.sv
module tap_detect_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_vld,
    input logic       latch_en,
    input logic       src_rd,
    input logic [3:0] evt_en,
    input logic [3:0] ev,
    input logic [4:0] src_q
);
    // R1: a flag can only appear after a sample was presented
    p_set_needs_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_q[3:0] & ~$past(src_q[3:0])) != 4'b0) |-> $past(smp_vld));

    // R5: a flag never sets while its enable is off
    p_set_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_q[3:0] & ~$past(src_q[3:0]) & ~$past(evt_en)) == 4'b0));

    // R6: latched flags persist until read
    p_latched_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && !src_rd) |=> ((src_q[3:0] & $past(src_q[3:0])) == $past(src_q[3:0])));

    // R6: a read with no new event empties the flags
    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rd && ev == 4'b0) |=> (src_q[3:0] == 4'b0));

    // R6: unlatched flags drop on the next sample
    p_unlatched_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_en && smp_vld && ev == 4'b0) |=> (src_q[3:0] == 4'b0));
endmodule

bind tap_detect tap_detect_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (smp_vld),
    .latch_en (latch_en),
    .src_rd   (src_rd),
    .evt_en   (evt_en),
    .ev       (ev_all),
    .src_q    (src_q)
);

// File: tb/tap_detect_test.sv
module tap_detect_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       smp_vld = 1'b0;
    logic [7:0] x_smp = '0;
    logic [7:0] y_smp = '0;
    logic [3:0] thr_x = 4'd4;
    logic [3:0] thr_y = 4'd4;
    logic [7:0] time_lim = 8'd3;
    logic [7:0] latency = 8'd1;
    logic [7:0] window = 8'd2;
    logic [3:0] evt_en = 4'hF;
    logic       latch_en = 1'b1;
    logic       src_rd = 1'b0;
    logic [4:0] src_q;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    tap_detect uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .smp_vld(smp_vld),
        .x_smp(x_smp), .y_smp(y_smp), .thr_x(thr_x), .thr_y(thr_y),
        .time_lim(time_lim), .latency(latency), .window(window),
        .evt_en(evt_en), .latch_en(latch_en), .src_rd(src_rd),
        .src_q(src_q), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [5:0] exp);
        logic [5:0] got;
        got = {irq, src_q};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic samp(input int x, input int y);
        smp_vld = 1'b1; x_smp = 8'(x); y_smp = 8'(y);
        @(negedge clk);
        smp_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic rd_clear();
        src_rd = 1'b1;
        @(negedge clk);
        src_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic click(input int axis, input int amp, input int w);
        if (axis == 0) samp(amp, 0); else samp(0, amp);
        ticks(w);
        samp(0, 0);
    endtask

    task automatic settle();
        ticks(24);
        rd_clear();
    endtask

    function automatic logic [5:0] expv(input logic [3:0] f);
        return {|f, |f, f};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R7 reset state", 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 after reset", 6'b0);

        // R1: threshold sweep, both polarities, both axes
        evt_en = 4'b0101;
        for (int ax = 0; ax < 2; ax++) begin
            for (int t = 1; t < 16; t++) begin
                thr_x = 4'(t); thr_y = 4'(t);
                for (int k = 0; k < 4; k++) begin
                    int amp;
                    logic hit;
                    amp = (k[0] ? t*4 + 1 : t*4) * (k[1] ? -1 : 1);
                    hit = k[0];
                    click(ax, amp, 1);
                    chk("R1 threshold", hit ? expv(ax == 0 ? 4'b0001 : 4'b0100) : 6'b0);
                    settle();
                end
            end
        end
        thr_x = 4'd4; thr_y = 4'd4;
        evt_en = 4'hF;

        // R2: pulse-width limit sweep
        time_lim = 8'd3;
        for (int w = 0; w < 7; w++) begin
            click(0, 40, w);
            chk("R2 width limit", (w <= 3) ? expv(4'b0001) : 6'b0);
            settle();
        end
        time_lim = 8'd0;
        click(0, 40, 0);
        chk("R2 zero limit short", expv(4'b0001));
        settle();
        click(0, 40, 1);
        chk("R2 zero limit long", 6'b0);
        settle();
        time_lim = 8'd3;

        // R3/R4: gap sweep, latency 2 ticks, window 4 ticks
        latency = 8'd1; window = 8'd2;
        for (int g = 0; g < 10; g++) begin
            click(0, 40, 1);
            ticks(g);
            rd_clear();
            click(0, 40, 1);
            if (g < 2)      chk("R3 start in dead time", 6'b0);
            else if (g < 6) chk("R3 double in window", expv(4'b0010));
            else            chk("R4 window expired new single", expv(4'b0001));
            settle();
        end
        // R3: zero dead time, window 2 ticks
        latency = 8'd0; window = 8'd1;
        for (int g = 0; g < 4; g++) begin
            click(1, -40, 1);
            ticks(g);
            rd_clear();
            click(1, -40, 1);
            if (g < 2) chk("R3 zero latency double", expv(4'b1000));
            else       chk("R4 zero latency expired", expv(4'b0100));
            settle();
        end
        latency = 8'd1; window = 8'd2;

        // R2: overlong second tap gives no double
        click(0, 40, 1);
        ticks(3);
        rd_clear();
        click(0, 40, 5);
        chk("R2 overlong second tap", 6'b0);
        settle();

        // R5: enable mask sweep on both axes
        for (int m = 0; m < 16; m++) begin
            evt_en = 4'(m);
            click(0, 40, 1); ticks(3); click(0, 40, 1);
            chk("R5 enable mask X", expv(4'(m) & 4'b0011));
            settle();
            click(1, 40, 1); ticks(3); click(1, 40, 1);
            chk("R5 enable mask Y", expv(4'(m) & 4'b1100));
            settle();
        end
        evt_en = 4'hF;

        // R6: unlatched vs latched behaviour
        latch_en = 1'b0;
        click(0, 40, 1);
        chk("R6 unlatched set", expv(4'b0001));
        samp(0, 0);
        chk("R6 unlatched cleared by sample", 6'b0);
        settle();
        latch_en = 1'b1;
        click(0, 40, 1);
        samp(0, 0); samp(0, 0); samp(0, 0);
        chk("R6 latched holds", expv(4'b0001));
        rd_clear();
        chk("R6 read clears", 6'b0);
        settle();

        // R8: Y single during X dead time, then X double
        click(0, 40, 1);
        ticks(1);
        click(1, 40, 1);
        click(0, 40, 1);
        chk("R8 axes independent", expv(4'b0111));
        settle();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule